// File: doc/BRIEF.md
# Decoder fault status and recovery sequencer

This block sits beside a variable-length bitstream decoder and turns the decoder's event pulses into sticky status flags, a masked level interrupt and a controlled shutdown after any error. Three events arrive from the decoder core: an unexpected start code, the end of a macroblock together with the run-length code emitted there, and the end of input DMA. Each event sets one or more flags. The flags stay set until the CPU clears them with a write-one-to-clear or issues a software reset.

An error never stops activity abruptly. When any error flag is set, the sequencer stops new bus work from starting and waits for transfers already in flight to finish. It then asks for the output buffers to be drained. After the drain is reported complete it raises a ready-for-reset indication, sets a matching flag, and stays in that state until the software reset arrives. A flush command from the CPU is honoured only when the decoder has stopped for the correct reason. The required reason depends on a mode input: the input-done interrupt in one mode, the start-code interrupt in the other.

Top module: `dec_fault_ctl`

## Requirements
- R1: A pulse on `ev_start_code` sets status bit 0 (start code seen) and status bit 1 (bitstream error) at the next clock edge. `sc_hold` is high whenever status bit 0 is set, which keeps the start code frozen in the decoder's shifter.
- R2: A pulse on `ev_mb_last` sets status bit 2 (run-length overflow) at the next edge only when `rl_code` differs from all ones. When `rl_code` is all ones the status is left unchanged.
- R3: A pulse on `ev_in_done` sets status bit 3. This bit is not an error and does not start the recovery sequence.
- R4: `err_any` is high exactly when status bit 1 or status bit 2 is set.
- R5: Status bits are sticky. A `wr_clr` cycle clears the bits that are set in `clr_mask`. An event arriving in the same cycle wins over the clear.
- R6: `irq` is high exactly when some status bit is set and its enable bit is also set. Enable bits are loaded from `ie_wdata` when `wr_ie` is high.
- R7: One edge after `err_any` is seen, `halt_new` goes high. The sequencer waits until `txn_busy` is sampled low, then holds `flush_req` high.
- R8: `rdy_reset` rises, and status bit 4 is set, at the edge where `flush_done` is sampled while `flush_req` is high. `rdy_reset` never rises while a transfer is busy or before the drain completes. It stays high until `sw_reset`.
- R9: `sw_reset` clears all status bits, drops `halt_new`, `flush_req` and `rdy_reset`, and leaves the enable bits unchanged. It takes priority over events in the same cycle.
- R10: `flush_ack` pulses one cycle after `flush_cmd` only in two cases. With `in_done_mode`=1, status bit 3 and its enable must both be set. With `in_done_mode`=0, status bit 0 and its enable must both be set. In every other case the command is ignored and no acknowledge appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_reset | input | 1 | CPU software reset pulse |
| ev_start_code | input | 1 | Unexpected start code event |
| ev_mb_last | input | 1 | Last data of a macroblock emitted |
| rl_code | input | RL_W | Run-length code at macroblock end |
| ev_in_done | input | 1 | Input DMA finished event |
| in_done_mode | input | 1 | Selects which stop reason qualifies a flush |
| wr_clr | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 5 | Status bits to clear |
| wr_ie | input | 1 | Enable mask write strobe |
| ie_wdata | input | 5 | New enable mask |
| txn_busy | input | 1 | A bus transaction is in flight |
| flush_done | input | 1 | Output buffer drain finished |
| flush_cmd | input | 1 | CPU flush command |
| status | output | 5 | Sticky flags: 0 start code, 1 bitstream error, 2 run-length overflow, 3 input done, 4 ready for reset |
| err_any | output | 1 | OR of error flags |
| irq | output | 1 | Masked level interrupt |
| halt_new | output | 1 | Block new bus transactions |
| flush_req | output | 1 | Request output buffer drain |
| rdy_reset | output | 1 | Ready for software reset |
| flush_ack | output | 1 | Flush command accepted |
| sc_hold | output | 1 | Freeze the decoder shifter |

## Verification
The bench drives random transaction latencies and confirms that ready-for-reset never appears while a transfer is busy or before the drain handshake completes. A design that skipped the drain wait would raise it early. The bench also drives clears that collide with events. A design that let the clear win would lose an error. It issues flush commands under both modes with the flag or the enable missing, which would expose a gate that ignores the mode or the mask. It applies a run-length code of all ones at macroblock end, which a design comparing the wrong value would report as an overflow.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
  localparam int NFLAG   = 5;
  localparam int FLG_SC  = 0;
  localparam int FLG_BSE = 1;
  localparam int FLG_RLO = 2;
  localparam int FLG_IND = 3;
  localparam int FLG_RDY = 4;
  localparam logic [NFLAG-1:0] ERR_MASK = (NFLAG'(1) << FLG_BSE) | (NFLAG'(1) << FLG_RLO);

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_DRAIN_TXN   = 2'd1,
    ST_FLUSH_OUT   = 2'd2,
    ST_READY_RESET = 2'd3
  } rec_state_t;
endpackage

// File: rtl/dfc_flags.sv
module dfc_flags import dfc_pkg::*; #(
  parameter int RL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_reset,
  input  logic             ev_sc,
  input  logic             ev_mb_last,
  input  logic [RL_W-1:0]  rl_code,
  input  logic             ev_in_done,
  input  logic             rdy_set,
  input  logic             wr_clr,
  input  logic [NFLAG-1:0] clr_mask,
  input  logic             wr_ie,
  input  logic [NFLAG-1:0] ie_wdata,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] ie,
  output logic             err_any,
  output logic             irq
);
  localparam logic [RL_W-1:0] RL_TERM = {RL_W{1'b1}};

  logic [NFLAG-1:0] set_v;
  logic [NFLAG-1:0] clr_v;

  always_comb begin
    set_v = '0;
    set_v[FLG_SC]  = ev_sc;
    set_v[FLG_BSE] = ev_sc;
    set_v[FLG_RLO] = ev_mb_last && (rl_code != RL_TERM);
    set_v[FLG_IND] = ev_in_done;
    set_v[FLG_RDY] = rdy_set;
    clr_v = wr_clr ? clr_mask : '0;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || sw_reset) flags[g] <= 1'b0;
      else if (set_v[g])   flags[g] <= 1'b1;
      else if (clr_v[g])   flags[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ie <= '0;
    else if (wr_ie) ie <= ie_wdata;
  end

  assign err_any = |(flags & ERR_MASK);
  assign irq     = |(flags & ie);

  // R1
  sc_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_sc && !sw_reset) |=> (flags[FLG_SC] && flags[FLG_BSE]));
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[FLG_BSE] && !sw_reset && !(wr_clr && clr_mask[FLG_BSE])) |=> flags[FLG_BSE]);
  // R2
  rl_term_chk: assert property (@(posedge clk) disable iff (rst)
    (!flags[FLG_RLO] && ev_mb_last && rl_code == RL_TERM) |=> !flags[FLG_RLO]);
endmodule

// File: rtl/dfc_seq.sv
module dfc_seq import dfc_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic sw_reset,
  input  logic err_any,
  input  logic txn_busy,
  input  logic flush_done,
  output logic halt_new,
  output logic flush_req,
  output logic rdy_reset,
  output logic rdy_set
);
  rec_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:        if (err_any)     st_nx = ST_DRAIN_TXN;
      ST_DRAIN_TXN:   if (!txn_busy)   st_nx = ST_FLUSH_OUT;
      ST_FLUSH_OUT:   if (flush_done)  st_nx = ST_READY_RESET;
      ST_READY_RESET: st_nx = ST_READY_RESET;
      default:        st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || sw_reset) st <= ST_IDLE;
    else                 st <= st_nx;
  end

  assign halt_new  = (st != ST_IDLE);
  assign flush_req = (st == ST_FLUSH_OUT);
  assign rdy_reset = (st == ST_READY_RESET);
  assign rdy_set   = (st == ST_FLUSH_OUT) && flush_done && !sw_reset;

  // R7
  err_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (err_any && !halt_new && !sw_reset) |=> halt_new);
  // R7
  no_busy_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_new && !flush_req && !rdy_reset && !sw_reset && txn_busy) |=> !flush_req);
  // R8
  rdy_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (!rdy_reset && !(flush_req && flush_done)) |=> !rdy_reset);
  // R9
  sw_idle_chk: assert property (@(posedge clk) disable iff (rst)
    sw_reset |=> (!halt_new && !rdy_reset));
endmodule

// File: rtl/dfc_flush_gate.sv
module dfc_flush_gate import dfc_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_reset,
  input  logic             flush_cmd,
  input  logic             in_done_mode,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] ie,
  output logic             flush_ack
);
  logic stop_ok;

  assign stop_ok = in_done_mode ? (flags[FLG_IND] && ie[FLG_IND])
                                : (flags[FLG_SC]  && ie[FLG_SC]);

  always_ff @(posedge clk) begin
    if (rst) flush_ack <= 1'b0;
    else     flush_ack <= flush_cmd && stop_ok && !sw_reset;
  end

  // R10
  ack_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (!flush_cmd) |=> !flush_ack);
endmodule

// File: rtl/dec_fault_ctl.sv
module dec_fault_ctl import dfc_pkg::*; #(
  parameter int RL_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_reset,
  input  logic            ev_start_code,
  input  logic            ev_mb_last,
  input  logic [RL_W-1:0] rl_code,
  input  logic            ev_in_done,
  input  logic            in_done_mode,
  input  logic            wr_clr,
  input  logic [4:0]      clr_mask,
  input  logic            wr_ie,
  input  logic [4:0]      ie_wdata,
  input  logic            txn_busy,
  input  logic            flush_done,
  input  logic            flush_cmd,
  output logic [4:0]      status,
  output logic            err_any,
  output logic            irq,
  output logic            halt_new,
  output logic            flush_req,
  output logic            rdy_reset,
  output logic            flush_ack,
  output logic            sc_hold
);
  logic [NFLAG-1:0] flags_w;
  logic [NFLAG-1:0] ie_w;
  logic             rdy_set_w;

  dfc_flags #(.RL_W(RL_W)) flags_i (
    .clk(clk), .rst(rst), .sw_reset(sw_reset),
    .ev_sc(ev_start_code), .ev_mb_last(ev_mb_last), .rl_code(rl_code),
    .ev_in_done(ev_in_done), .rdy_set(rdy_set_w),
    .wr_clr(wr_clr), .clr_mask(clr_mask), .wr_ie(wr_ie), .ie_wdata(ie_wdata),
    .flags(flags_w), .ie(ie_w), .err_any(err_any), .irq(irq)
  );

  dfc_seq seq_i (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .err_any(err_any),
    .txn_busy(txn_busy), .flush_done(flush_done),
    .halt_new(halt_new), .flush_req(flush_req), .rdy_reset(rdy_reset),
    .rdy_set(rdy_set_w)
  );

  dfc_flush_gate gate_i (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .flush_cmd(flush_cmd),
    .in_done_mode(in_done_mode), .flags(flags_w), .ie(ie_w),
    .flush_ack(flush_ack)
  );

  assign status  = flags_w;
  assign sc_hold = flags_w[FLG_SC];

  // R8
  rdy_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_reset) |-> status[FLG_RDY]);
endmodule

// File: tb/dec_fault_ctl_tb.sv
module dec_fault_ctl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sw_reset, ev_start_code, ev_mb_last, ev_in_done, in_done_mode;
  logic [7:0] rl_code;
  logic wr_clr, wr_ie, txn_busy, flush_done, flush_cmd;
  logic [4:0] clr_mask, ie_wdata, status;
  logic err_any, irq, halt_new, flush_req, rdy_reset, flush_ack, sc_hold;

  dec_fault_ctl #(.RL_W(8)) dut_i (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .ev_start_code(ev_start_code),
    .ev_mb_last(ev_mb_last), .rl_code(rl_code), .ev_in_done(ev_in_done),
    .in_done_mode(in_done_mode), .wr_clr(wr_clr), .clr_mask(clr_mask),
    .wr_ie(wr_ie), .ie_wdata(ie_wdata), .txn_busy(txn_busy),
    .flush_done(flush_done), .flush_cmd(flush_cmd), .status(status),
    .err_any(err_any), .irq(irq), .halt_new(halt_new), .flush_req(flush_req),
    .rdy_reset(rdy_reset), .flush_ack(flush_ack), .sc_hold(sc_hold)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [4:0] m_f, m_ie;
  int m_s;
  logic m_ack;
  int busy_cnt;
  logic prev_rdy;
  bit drained;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_in();
    sw_reset = 0; ev_start_code = 0; ev_mb_last = 0; rl_code = 8'h00;
    ev_in_done = 0; wr_clr = 0; clr_mask = 0; wr_ie = 0; ie_wdata = 0;
    flush_done = 0; flush_cmd = 0;
  endtask

  function automatic logic [4:0] set_of(input int st);
    logic [4:0] s = 0;
    if (ev_start_code) s |= 5'b00011;
    if (ev_mb_last && rl_code != 8'hFF) s |= 5'b00100;
    if (ev_in_done) s |= 5'b01000;
    if (st == 2 && flush_done) s |= 5'b10000;
    return s;
  endfunction

  task automatic tick();
    logic [4:0] of, oie;
    int os;
    @(posedge clk);
    of = m_f; oie = m_ie; os = m_s;
    m_ack = !sw_reset && flush_cmd &&
            (in_done_mode ? (of[3] && oie[3]) : (of[0] && oie[0]));
    if (wr_ie) m_ie = ie_wdata;
    if (sw_reset) begin
      m_f = 0; m_s = 0; drained = 0;
    end else begin
      m_f = (of & ~(wr_clr ? clr_mask : 5'b0)) | set_of(os);
      case (os)
        0: if (|(of & 5'b00110)) m_s = 1;
        1: if (!txn_busy) m_s = 2;
        2: if (flush_done) begin m_s = 3; drained = 1; end
        default: ;
      endcase
    end
    @(negedge clk);
    chk("R5", "status", status, m_f);
    chk("R4", "err_any", err_any, |(m_f & 5'b00110));
    chk("R6", "irq", irq, |(m_f & m_ie));
    chk("R7", "halt_new", halt_new, m_s != 0);
    chk("R7", "flush_req", flush_req, m_s == 2);
    chk("R8", "rdy_reset", rdy_reset, m_s == 3);
    chk("R10", "flush_ack", flush_ack, m_ack);
    chk("R1", "sc_hold", sc_hold, m_f[0]);
    if (rdy_reset && !prev_rdy) begin
      chk("R8", "rdy rose while busy", txn_busy, 0);
      chk("R8", "rdy rose before drain", drained, 1);
    end
    prev_rdy = rdy_reset;
    clr_in();
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clr_in(); in_done_mode = 0; txn_busy = 0; rst = 1;
    m_f = 0; m_ie = 0; m_s = 0; m_ack = 0; busy_cnt = 0; prev_rdy = 0; drained = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // reset state
    chk("R9", "status after reset", status, 0);
    chk("R6", "irq after reset", irq, 0);
    chk("R8", "rdy after reset", rdy_reset, 0);

    // R2: all-ones code leaves status alone, other code sets bit 2
    ev_mb_last = 1; rl_code = 8'hFF; tick();
    chk("R2", "all-ones rl_code", status[2], 0);
    ev_mb_last = 1; rl_code = 8'h3C; tick();
    chk("R2", "overflow rl_code", status[2], 1);
    // drain with busy transaction
    txn_busy = 1; tick(); tick(); txn_busy = 0; tick(); tick();
    chk("R7", "flush_req after busy", flush_req, 1);
    flush_done = 1; tick();
    chk("R8", "ready after drain", rdy_reset, 1);
    chk("R8", "ready flag", status[4], 1);
    // R9: sw_reset with simultaneous event; enable kept
    wr_ie = 1; ie_wdata = 5'b01001; tick();
    sw_reset = 1; ev_start_code = 1; tick();
    chk("R9", "status after sw_reset", status, 0);
    chk("R9", "rdy after sw_reset", rdy_reset, 0);
    // R3: input done is not an error
    ev_in_done = 1; tick(); tick(); tick();
    chk("R3", "in_done no halt", halt_new, 0);
    chk("R6", "irq from in_done", irq, 1);
    // R10 gating in both modes
    in_done_mode = 0; flush_cmd = 1; tick(); tick();
    chk("R10", "mode0 without sc", flush_ack, 0);
    in_done_mode = 1; flush_cmd = 1; tick();
    chk("R10", "mode1 qualified", flush_ack, 1);
    wr_clr = 1; clr_mask = 5'b01000; ev_in_done = 1; tick();
    chk("R5", "set wins over clear", status[3], 1);
    wr_ie = 1; ie_wdata = 5'b00001; tick();
    flush_cmd = 1; tick();
    chk("R10", "mode1 enable off", flush_ack, 0);
    // R1: start code
    ev_start_code = 1; tick();
    chk("R1", "start code flags", status[1:0], 2'b11);
    in_done_mode = 0; flush_cmd = 1; tick();
    chk("R10", "mode0 qualified", flush_ack, 1);
    sw_reset = 1; tick();

    // constrained random phase
    for (int i = 0; i < 6000; i++) begin
      if (busy_cnt == 0 && !halt_new && ($urandom % 4 == 0)) busy_cnt = 1 + $urandom % 6;
      txn_busy = (busy_cnt != 0);
      if (busy_cnt != 0) busy_cnt--;
      ev_start_code = ($urandom % 60 == 0);
      ev_mb_last = ($urandom % 8 == 0);
      rl_code = ($urandom % 3 == 0) ? 8'($urandom) : 8'hFF;
      ev_in_done = ($urandom % 30 == 0);
      wr_clr = ($urandom % 10 == 0); clr_mask = 5'($urandom);
      wr_ie = ($urandom % 40 == 0); ie_wdata = 5'($urandom);
      flush_done = flush_req && ($urandom % 4 == 0);
      flush_cmd = ($urandom % 6 == 0);
      in_done_mode = ($urandom % 2 == 0);
      sw_reset = (rdy_reset && ($urandom % 5 == 0)) || ($urandom % 400 == 0);
      tick();
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule